// File: doc/BRIEF.md
# Parallel Port Register Block

This block sits on an 8-bit processor data bus and gives software two full-width bidirectional ports (A and B) and one narrow 4-bit bidirectional port (C). Each port owns an output latch and a direction register, all placed in an eight-address window whose base is a parameter. For every pin the block drives an output value and an output enable; the pad itself, pull-ups and tri-state modelling live outside.

Writes are synchronous: they take effect on the rising clock edge, and only when the clock-enable input is high and the address lands inside the window. Reads are combinational and return in the same cycle. A data read merges, bit by bit, the latch value for pins configured as outputs with the external pin level for pins configured as inputs. Direction registers cannot be read back, and unused or reserved slots return all ones.

Top module: `parallel_port_regs`

## Requirements
- R1: After reset every output latch is 0 and every direction bit is 0, so all output enables are low and all output values are 0.
- R2: A write with cen high to window offset 0, 1 or 2 loads the port A, B or C output latch on that clock edge, visible on the output pins from the next cycle; port C keeps only bus bits 3:0.
- R3: A write with cen high to offset 4, 5 or 6 loads the direction register of port A, B or C; a direction bit of 1 raises that pin's output enable, 0 lowers it. Port C keeps only bus bits 3:0.
- R4: A write presented while cen is low changes no latch and no direction register.
- R5: A read of offset 0, 1 or 2 returns, per bit, the output latch value where the direction bit is 1 and the external pin input where it is 0.
- R6: A read of port C data (offset 2) returns ones in bits 7:4.
- R7: A read of any direction register (offsets 4, 5, 6) returns 0xFF whatever it holds.
- R8: Offsets 3 and 7 are reserved: reads return 0xFF and writes change no port state.
- R9: A data write to a bit configured as input still updates its latch; the pin keeps reading the external input, and the stored value shows on the output and in reads once that bit is switched to output.
- R10: An access whose address is outside the window writes nothing, holds rdValid low and returns rdData 0.
- R11: A read inside the window raises rdValid combinationally in the same cycle as rdEn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| cen | input | 1 | Clock enable qualifying writes |
| addr | input | ADDR_W | Bus address |
| wrEn | input | 1 | Write request |
| rdEn | input | 1 | Read request |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data, 0 when not valid |
| rdValid | output | 1 | Read hit inside the window |
| paIn | input | DATA_W | Port A pin levels |
| paOut | output | DATA_W | Port A output latch |
| paOe | output | DATA_W | Port A output enables |
| pbIn | input | DATA_W | Port B pin levels |
| pbOut | output | DATA_W | Port B output latch |
| pbOe | output | DATA_W | Port B output enables |
| pcIn | input | NARROW_W | Port C pin levels |
| pcOut | output | NARROW_W | Port C output latch |
| pcOe | output | NARROW_W | Port C output enables |

## Verification
The bench builds the block with an 11-bit address and the window based at 0x018 rather than zero, so addresses on both sides of the window (0x010, 0x020) and one differing only in a high address bit (0x418) reach the out-of-window decode. The default 8-bit data width with a 4-bit narrow port puts the ones-padding of port C reads and the truncation of its direction and data writes within reach, while full-width ports A and B exercise mixed direction patterns in the read merge.

// File: rtl/pp_pkg.sv
package pp_pkg;

  localparam int NUM_PORTS = 3;
  localparam int OFF_W     = 3;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_ONES,
    RD_PORT
  } rdKind_t;

  typedef struct packed {
    logic [NUM_PORTS-1:0] wrLatch;
    logic [NUM_PORTS-1:0] wrDir;
    rdKind_t              rdKind;
    logic [1:0]           rdPort;
  } ppStrobes_t;

  // Last port is the narrow one; the others are full width.
  function automatic int portWidth(int p, int wideW, int narrowW);
    return (p == NUM_PORTS - 1) ? narrowW : wideW;
  endfunction

  function automatic int portBase(int p, int wideW);
    return p * wideW;
  endfunction

endpackage

// File: rtl/pp_port.sv
module pp_port #(
  parameter int W      = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrLatch,
  input  logic              wrDir,
  input  logic [W-1:0]      wrBus,
  input  logic [W-1:0]      pinIn,
  output logic [W-1:0]      latchQ,
  output logic [W-1:0]      dirQ,
  output logic [DATA_W-1:0] readVal
);

  logic [W-1:0] merged;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= '0;
      dirQ   <= '0;
    end else begin
      if (wrLatch) latchQ <= wrBus;
      if (wrDir)   dirQ   <= wrBus;
    end
  end

  assign merged = (latchQ & dirQ) | (pinIn & ~dirQ);

  generate
    if (W < DATA_W) begin : g_pad
      assign readVal = {{(DATA_W - W){1'b1}}, merged};
    end else begin : g_full
      assign readVal = merged;
    end
  endgenerate

  assert_latch_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrLatch |=> (latchQ == $past(wrBus)));

  assert_dir_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrDir |=> (dirQ == $past(wrBus)));

  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!wrLatch && !wrDir) |=> ($stable(latchQ) && $stable(dirQ)));

endmodule

// File: rtl/pp_ctrl.sv
module pp_ctrl
  import pp_pkg::*;
#(
  parameter int                ADDR_W      = 11,
  parameter logic [ADDR_W-1:0] WINDOW_BASE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cen,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output ppStrobes_t        stb
);

  localparam logic [ADDR_W-OFF_W-1:0] BASE_HI = WINDOW_BASE[ADDR_W-1:OFF_W];

  logic       hit;
  logic       isDir;
  logic [1:0] slot;
  logic       slotLive;

  assign hit      = (addr[ADDR_W-1:OFF_W] == BASE_HI);
  assign isDir    = addr[OFF_W-1];
  assign slot     = addr[1:0];
  assign slotLive = (int'(slot) < NUM_PORTS);

  always_comb begin
    stb        = '0;
    stb.rdKind = RD_NONE;
    if (hit && cen && wrEn && slotLive) begin
      if (isDir) stb.wrDir[slot]   = 1'b1;
      else       stb.wrLatch[slot] = 1'b1;
    end
    if (hit && rdEn) begin
      if (isDir || !slotLive) begin
        stb.rdKind = RD_ONES;
      end else begin
        stb.rdKind = RD_PORT;
        stb.rdPort = slot;
      end
    end
  end

  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrLatch, stb.wrDir}));

  assert_cen_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    !cen |-> ($countones({stb.wrLatch, stb.wrDir}) == 0));

endmodule

// File: rtl/pp_datapath.sv
module pp_datapath
  import pp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int WIDE_W   = 8,
  parameter int NARROW_W = 4,
  localparam int TOTAL_W = (NUM_PORTS - 1) * WIDE_W + NARROW_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  ppStrobes_t         stb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [TOTAL_W-1:0] pinsIn,
  output logic [TOTAL_W-1:0] pinsOut,
  output logic [TOTAL_W-1:0] pinsOe,
  output logic [DATA_W-1:0]  rdData,
  output logic               rdValid
);

  logic [DATA_W-1:0] portRead [NUM_PORTS];

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      localparam int PW = portWidth(p, WIDE_W, NARROW_W);
      localparam int PB = portBase(p, WIDE_W);
      pp_port #(.W(PW), .DATA_W(DATA_W)) u_port (
        .clk     (clk),
        .rstN    (rstN),
        .wrLatch (stb.wrLatch[p]),
        .wrDir   (stb.wrDir[p]),
        .wrBus   (wrData[PW-1:0]),
        .pinIn   (pinsIn[PB +: PW]),
        .latchQ  (pinsOut[PB +: PW]),
        .dirQ    (pinsOe[PB +: PW]),
        .readVal (portRead[p])
      );
    end
  endgenerate

  always_comb begin
    rdData = '0;
    unique case (stb.rdKind)
      RD_ONES: rdData = '1;
      RD_PORT: rdData = (int'(stb.rdPort) < NUM_PORTS) ? portRead[stb.rdPort] : '1;
      default: rdData = '0;
    endcase
  end

  assign rdValid = (stb.rdKind != RD_NONE);

  assert_read_kind_R11: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdKind == RD_NONE) |-> (rdData == '0));

endmodule

// File: rtl/parallel_port_regs.sv
module parallel_port_regs
  import pp_pkg::*;
#(
  parameter int                ADDR_W      = 11,
  parameter int                DATA_W      = 8,
  parameter int                NARROW_W    = 4,
  parameter logic [ADDR_W-1:0] WINDOW_BASE = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cen,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  output logic                rdValid,
  input  logic [DATA_W-1:0]   paIn,
  output logic [DATA_W-1:0]   paOut,
  output logic [DATA_W-1:0]   paOe,
  input  logic [DATA_W-1:0]   pbIn,
  output logic [DATA_W-1:0]   pbOut,
  output logic [DATA_W-1:0]   pbOe,
  input  logic [NARROW_W-1:0] pcIn,
  output logic [NARROW_W-1:0] pcOut,
  output logic [NARROW_W-1:0] pcOe
);

  localparam int WIDE_W  = DATA_W;
  localparam int TOTAL_W = (NUM_PORTS - 1) * WIDE_W + NARROW_W;

  ppStrobes_t         stb;
  logic [TOTAL_W-1:0] pinsIn;
  logic [TOTAL_W-1:0] pinsOut;
  logic [TOTAL_W-1:0] pinsOe;

  assign pinsIn = {pcIn, pbIn, paIn};
  assign {pcOut, pbOut, paOut} = pinsOut;
  assign {pcOe,  pbOe,  paOe}  = pinsOe;

  pp_ctrl #(.ADDR_W(ADDR_W), .WINDOW_BASE(WINDOW_BASE)) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .cen  (cen),
    .addr (addr),
    .wrEn (wrEn),
    .rdEn (rdEn),
    .stb  (stb)
  );

  pp_datapath #(.DATA_W(DATA_W), .WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (wrData),
    .pinsIn  (pinsIn),
    .pinsOut (pinsOut),
    .pinsOe  (pinsOe),
    .rdData  (rdData),
    .rdValid (rdValid)
  );

  // Independent window decode used only by the checks below.
  logic inWin;
  assign inWin = (addr[ADDR_W-1:OFF_W] == WINDOW_BASE[ADDR_W-1:OFF_W]);

  assert_outside_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !inWin |-> (!rdValid && rdData == '0));

  assert_outside_no_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    !inWin |=> ($stable(pinsOut) && $stable(pinsOe)));

  assert_cen_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !cen |=> ($stable(pinsOut) && $stable(pinsOe)));

  assert_dir_reads_ones_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && inWin && addr[2] && addr[1:0] != 2'b11) |-> (rdData == '1));

  assert_reserved_ones_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && inWin && addr[1:0] == 2'b11) |-> (rdData == '1));

  assert_narrow_upper_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && inWin && addr[2:0] == 3'd2) |-> (&rdData[DATA_W-1:NARROW_W]));

  assert_valid_hit_R11: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && inWin) |-> rdValid);

endmodule

// File: tb/parallel_port_regs_bench.sv
module parallel_port_regs_bench;

  localparam int          ADDR_W = 11;
  localparam logic [10:0] BASE   = 11'h018;

  localparam logic [10:0] A_DAT = BASE + 11'd0;
  localparam logic [10:0] B_DAT = BASE + 11'd1;
  localparam logic [10:0] C_DAT = BASE + 11'd2;
  localparam logic [10:0] RSV3  = BASE + 11'd3;
  localparam logic [10:0] A_DIR = BASE + 11'd4;
  localparam logic [10:0] B_DIR = BASE + 11'd5;
  localparam logic [10:0] C_DIR = BASE + 11'd6;
  localparam logic [10:0] RSV7  = BASE + 11'd7;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cen = 1'b1;
  logic [10:0] addr = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic        rdValid;
  logic [7:0]  paIn = '0, pbIn = '0;
  logic [3:0]  pcIn = '0;
  logic [7:0]  paOut, paOe, pbOut, pbOe;
  logic [3:0]  pcOut, pcOe;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  parallel_port_regs #(.ADDR_W(ADDR_W), .DATA_W(8), .NARROW_W(4), .WINDOW_BASE(BASE))
    u_parallel_port_regs (
      .clk, .rstN, .cen, .addr, .wrEn, .rdEn, .wrData, .rdData, .rdValid,
      .paIn, .paOut, .paOe, .pbIn, .pbOut, .pbOe, .pcIn, .pcOut, .pcOe);

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [10:0] a, input logic [7:0] d, input logic c);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1; cen = c;
    @(negedge clk);
    wrEn = 1'b0; cen = 1'b1;
  endtask

  task automatic readReg(input logic [10:0] a, output logic [7:0] d, output logic v);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #2;
    d = rdData; v = rdValid;
    rdEn = 1'b0;
  endtask

  task automatic testReset();
    logic [7:0] d; logic v;
    check("R1 paOut", paOut, 8'h00);
    check("R1 pbOut", pbOut, 8'h00);
    check("R1 pcOut", {4'h0, pcOut}, 8'h00);
    check("R1 paOe", paOe, 8'h00);
    check("R1 pbOe", pbOe, 8'h00);
    check("R1 pcOe", {4'h0, pcOe}, 8'h00);
    paIn = 8'h5A;
    readReg(A_DAT, d, v);
    check("R1 read A all inputs", d, 8'h5A);
  endtask

  task automatic testPortA();
    logic [7:0] d; logic v;
    writeReg(A_DIR, 8'hFF, 1'b1);
    check("R3 paOe all out", paOe, 8'hFF);
    writeReg(A_DAT, 8'h3C, 1'b1);
    check("R2 paOut", paOut, 8'h3C);
    paIn = 8'hC3;
    readReg(A_DAT, d, v);
    check("R5 read A outputs", d, 8'h3C);
    check("R11 valid A", {7'd0, v}, 8'h01);
  endtask

  task automatic testMergeB();
    logic [7:0] d; logic v;
    writeReg(B_DIR, 8'hF0, 1'b1);
    check("R3 pbOe", pbOe, 8'hF0);
    pbIn = 8'h55;
    writeReg(B_DAT, 8'hAA, 1'b1);
    check("R2 pbOut", pbOut, 8'hAA);
    readReg(B_DAT, d, v);
    check("R5 read B mixed", d, 8'hA5);
  endtask

  task automatic testNarrowC();
    logic [7:0] d; logic v;
    writeReg(C_DAT, 8'hFF, 1'b1);
    check("R2 pcOut low nibble", {4'h0, pcOut}, 8'h0F);
    writeReg(C_DIR, 8'h3A, 1'b1);
    check("R3 pcOe low nibble", {4'h0, pcOe}, 8'h0A);
    pcIn = 4'h0;
    readReg(C_DAT, d, v);
    check("R6 read C upper ones", d, 8'hFA);
  endtask

  task automatic testDirReads();
    logic [7:0] d; logic v;
    readReg(A_DIR, d, v);
    check("R7 read A dir", d, 8'hFF);
    check("R11 valid dir", {7'd0, v}, 8'h01);
    readReg(B_DIR, d, v);
    check("R7 read B dir", d, 8'hFF);
    readReg(C_DIR, d, v);
    check("R7 read C dir", d, 8'hFF);
  endtask

  task automatic testReserved();
    logic [7:0] d; logic v;
    writeReg(RSV3, 8'h00, 1'b1);
    writeReg(RSV7, 8'h00, 1'b1);
    check("R8 paOut kept", paOut, 8'h3C);
    check("R8 pbOe kept", pbOe, 8'hF0);
    check("R8 pcOe kept", {4'h0, pcOe}, 8'h0A);
    readReg(RSV3, d, v);
    check("R8 read slot 3", d, 8'hFF);
    readReg(RSV7, d, v);
    check("R8 read slot 7", d, 8'hFF);
  endtask

  task automatic testCen();
    writeReg(A_DAT, 8'h11, 1'b0);
    check("R4 latch held", paOut, 8'h3C);
    writeReg(A_DIR, 8'h00, 1'b0);
    check("R4 dir held", paOe, 8'hFF);
  endtask

  task automatic testHiddenLatch();
    logic [7:0] d; logic v;
    writeReg(B_DIR, 8'h00, 1'b1);
    writeReg(B_DAT, 8'h77, 1'b1);
    check("R9 oe still low", pbOe, 8'h00);
    readReg(B_DAT, d, v);
    check("R9 read shows pins", d, 8'h55);
    writeReg(B_DIR, 8'hFF, 1'b1);
    check("R9 oe raised", pbOe, 8'hFF);
    check("R9 stored value out", pbOut, 8'h77);
    readReg(B_DAT, d, v);
    check("R9 read stored value", d, 8'h77);
  endtask

  task automatic testOutside();
    logic [7:0] d; logic v;
    writeReg(11'h010, 8'h99, 1'b1);
    writeReg(11'h420, 8'h99, 1'b1);
    writeReg(11'h418, 8'h99, 1'b1);
    check("R10 no write A", paOut, 8'h3C);
    check("R10 no write dirA", paOe, 8'hFF);
    readReg(11'h010, d, v);
    check("R10 valid below", {7'd0, v}, 8'h00);
    check("R10 data below", d, 8'h00);
    readReg(11'h020, d, v);
    check("R10 valid above", {7'd0, v}, 8'h00);
    readReg(11'h418, d, v);
    check("R10 valid high alias", {7'd0, v}, 8'h00);
    check("R10 data high alias", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPortA();
    testMergeB();
    testNarrowC();
    testDirReads();
    testReserved();
    testCen();
    testHiddenLatch();
    testOutside();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule